// File: doc/BRIEF.md
# Shared Read-Return Combiner for APB Completers

This block sits between several APB completers and the single requester that reads them. Each completer presents its own read data, ready and error lines. The block first masks each completer's read data with that completer's own select and the common read direction. It then ORs the masked vectors into one read-data bus. The requester samples that bus on the rising clock edge where ready is high during the access phase. Ready and error toward the requester are taken only from the selected completer. When no completer is selected, ready reads high and error reads low.

The block also watches for bus-ownership faults that a protocol checker cannot see. One fault is an unselected completer that drives nonzero data on its return. Another is two completers contributing read data in the same access. A multi-hot select vector raises its own separate select-conflict flag. The ownership check uses the raw, unmasked data, so a misbehaving completer is caught even though the mask keeps its data off the shared bus. Each flag has a sticky copy, which holds until reset, and a one-cycle pulse copy.

Top module: `apb_ret_combiner`

## Requirements
- R1: Completer i's read data, bits [i*DATA_W +: DATA_W] of `comp_rdata`, reaches `prdata` only while `comp_sel[i]` is 1 and `pwrite` is 0. Otherwise its contribution is all zeros. A selected write therefore gives `prdata` = 0.
- R2: `prdata` is the bitwise OR of all masked completer read-data vectors, with no register stage. When two completers are read at once, `prdata` is the OR of their data.
- R3: `pready` is the OR of `comp_ready[i]` over the selected completers, and `pslverr` is the OR of `comp_err[i]` over the selected completers. Ready and error from unselected completers have no effect. With no select bit set, `pready` = 1 and `pslverr` = 0.
- R4: An unselected completer whose raw read data is nonzero, in any cycle, is an ownership violation.
- R5: A cycle with `penable` = 1, `pwrite` = 0 and more than one select bit set is an ownership violation, because more than one completer contributes.
- R6: More than one select bit set in a cycle, whatever `pwrite` and `penable` are, is a select conflict.
- R7: After each clock edge at which a violation (from R4 or R5) or a conflict (from R6) was present, the matching pulse output is 1 for the following cycle. Otherwise the pulse is 0. The matching sticky output rises at that same edge and stays 1 until reset.
- R8: Reset is synchronous and active high (`rst`). At the first edge with reset high, both pulse outputs and both sticky outputs clear to 0.
- R9: A stray driver is flagged as in R4 while `prdata` still equals the addressed completer's data, because the mask keeps the stray data off the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pwrite | input | 1 | Common transfer direction; 1 = write |
| penable | input | 1 | Common access-phase indicator |
| comp_sel | input | N_COMP | Per-completer select; bit i selects completer i |
| comp_rdata | input | N_COMP*DATA_W | Raw per-completer read data; completer i at [i*DATA_W +: DATA_W] |
| comp_ready | input | N_COMP | Per-completer ready |
| comp_err | input | N_COMP | Per-completer slave error |
| prdata | output | DATA_W | Combined read data toward the requester |
| pready | output | 1 | Combined ready toward the requester |
| pslverr | output | 1 | Combined error toward the requester |
| own_err_pulse | output | 1 | One-cycle marker of an ownership violation |
| own_err_sticky | output | 1 | Ownership violation seen since reset |
| sel_err_pulse | output | 1 | One-cycle marker of a select conflict |
| sel_err_sticky | output | 1 | Select conflict seen since reset |

## Verification
Several functions can fall in the same cycle. In a read with two select bits set and `penable` high, the OR merge, the two-contributor ownership check and the select-conflict check all act together. In a single-completer read with a stray driver, the correct data reaches `prdata` while the ownership pulse is raised for the next cycle. The bench creates both cases by driving overlapping selects and stray nonzero data on unselected completers. A behavioural model predicts the combined outputs in the same cycle and the pulse and sticky flags one edge later, and the bench compares them against the design on every clock.

// File: rtl/apb_ret_pkg.sv
package apb_ret_pkg;

    localparam int DEF_N_COMP = 4;
    localparam int DEF_DATA_W = 32;

    // One cycle's worth of ownership findings
    typedef struct packed {
        logic stray_drv;   // unselected completer drives nonzero data
        logic multi_rd;    // more than one completer contributes to a read access
        logic sel_multi;   // select vector is multi-hot
    } viol_t;

    // Registered flag state
    typedef struct packed {
        logic own_pulse;
        logic own_sticky;
        logic sel_pulse;
        logic sel_sticky;
    } flag_t;

    localparam flag_t FLAG_CLEAR = '{own_pulse: 1'b0, own_sticky: 1'b0,
                                     sel_pulse: 1'b0, sel_sticky: 1'b0};

    function automatic flag_t next_flags(input flag_t cur, input viol_t v);
        flag_t n;
        n.own_pulse  = v.stray_drv | v.multi_rd;
        n.own_sticky = cur.own_sticky | n.own_pulse;
        n.sel_pulse  = v.sel_multi;
        n.sel_sticky = cur.sel_sticky | v.sel_multi;
        return n;
    endfunction

endpackage

// File: rtl/ret_gate.sv
module ret_gate #(
    parameter int N_COMP = apb_ret_pkg::DEF_N_COMP,
    parameter int DATA_W = apb_ret_pkg::DEF_DATA_W
) (
    input  logic [N_COMP-1:0]        comp_sel,
    input  logic                     pwrite,
    input  logic [N_COMP*DATA_W-1:0] raw_rdata,
    output logic [N_COMP*DATA_W-1:0] masked_rdata,
    output logic [N_COMP-1:0]        stray_vec
);
    for (genvar i = 0; i < N_COMP; i++) begin : g_port
        logic lets_through;
        assign lets_through = comp_sel[i] & ~pwrite;
        assign masked_rdata[i*DATA_W +: DATA_W] =
            lets_through ? raw_rdata[i*DATA_W +: DATA_W] : '0;
        // raw data is inspected so the mask cannot hide a stray driver
        assign stray_vec[i] = ~comp_sel[i] & (|raw_rdata[i*DATA_W +: DATA_W]);
    end
endmodule

// File: rtl/ret_merge.sv
module ret_merge #(
    parameter int N_COMP = apb_ret_pkg::DEF_N_COMP,
    parameter int DATA_W = apb_ret_pkg::DEF_DATA_W
) (
    input  logic [N_COMP*DATA_W-1:0] masked_rdata,
    input  logic [N_COMP-1:0]        comp_sel,
    input  logic [N_COMP-1:0]        comp_ready,
    input  logic [N_COMP-1:0]        comp_err,
    output logic [DATA_W-1:0]        prdata,
    output logic                     pready,
    output logic                     pslverr
);
    logic any_sel;
    assign any_sel = |comp_sel;

    always_comb begin
        prdata = '0;
        for (int i = 0; i < N_COMP; i++) begin
            prdata = prdata | masked_rdata[i*DATA_W +: DATA_W];
        end
    end

    assign pready  = any_sel ? |(comp_sel & comp_ready) : 1'b1;
    assign pslverr = |(comp_sel & comp_err);
endmodule

// File: rtl/own_monitor.sv
module own_monitor
    import apb_ret_pkg::*;
#(
    parameter int N_COMP = DEF_N_COMP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_COMP-1:0] comp_sel,
    input  logic              pwrite,
    input  logic              penable,
    input  logic [N_COMP-1:0] stray_vec,
    output logic              own_err_pulse,
    output logic              own_err_sticky,
    output logic              sel_err_pulse,
    output logic              sel_err_sticky
);
    viol_t v;
    flag_t flags_q;

    always_comb begin
        v.stray_drv = |stray_vec;
        v.sel_multi = $countones(comp_sel) > 1;
        v.multi_rd  = v.sel_multi & penable & ~pwrite;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= FLAG_CLEAR;
        else     flags_q <= next_flags(flags_q, v);
    end

    assign own_err_pulse  = flags_q.own_pulse;
    assign own_err_sticky = flags_q.own_sticky;
    assign sel_err_pulse  = flags_q.sel_pulse;
    assign sel_err_sticky = flags_q.sel_sticky;

    // R7
    own_sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        own_err_sticky |=> own_err_sticky);
    // R7
    sel_pulse_implies_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sel_err_pulse |-> sel_err_sticky);
    // R6
    sel_conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(comp_sel) > 1) |=> sel_err_pulse);
    // R4
    stray_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|stray_vec) |=> (own_err_pulse && own_err_sticky));
endmodule

// File: rtl/apb_ret_combiner.sv
module apb_ret_combiner #(
    parameter int N_COMP = apb_ret_pkg::DEF_N_COMP,
    parameter int DATA_W = apb_ret_pkg::DEF_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pwrite,
    input  logic                     penable,
    input  logic [N_COMP-1:0]        comp_sel,
    input  logic [N_COMP*DATA_W-1:0] comp_rdata,
    input  logic [N_COMP-1:0]        comp_ready,
    input  logic [N_COMP-1:0]        comp_err,
    output logic [DATA_W-1:0]        prdata,
    output logic                     pready,
    output logic                     pslverr,
    output logic                     own_err_pulse,
    output logic                     own_err_sticky,
    output logic                     sel_err_pulse,
    output logic                     sel_err_sticky
);
    logic [N_COMP*DATA_W-1:0] masked_rdata;
    logic [N_COMP-1:0]        stray_vec;

    ret_gate #(.N_COMP(N_COMP), .DATA_W(DATA_W)) u_gate (
        .comp_sel     (comp_sel),
        .pwrite       (pwrite),
        .raw_rdata    (comp_rdata),
        .masked_rdata (masked_rdata),
        .stray_vec    (stray_vec)
    );

    ret_merge #(.N_COMP(N_COMP), .DATA_W(DATA_W)) u_merge (
        .masked_rdata (masked_rdata),
        .comp_sel     (comp_sel),
        .comp_ready   (comp_ready),
        .comp_err     (comp_err),
        .prdata       (prdata),
        .pready       (pready),
        .pslverr      (pslverr)
    );

    own_monitor #(.N_COMP(N_COMP)) u_mon (
        .clk            (clk),
        .rst            (rst),
        .comp_sel       (comp_sel),
        .pwrite         (pwrite),
        .penable        (penable),
        .stray_vec      (stray_vec),
        .own_err_pulse  (own_err_pulse),
        .own_err_sticky (own_err_sticky),
        .sel_err_pulse  (sel_err_pulse),
        .sel_err_sticky (sel_err_sticky)
    );

    // R3
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (comp_sel == '0) |-> (pready && !pslverr && prdata == '0));

    for (genvar i = 0; i < N_COMP; i++) begin : g_chk
        // R1
        single_read_route_chk: assert property (@(posedge clk) disable iff (rst)
            (comp_sel == (N_COMP'(1) << i) && !pwrite)
            |-> (prdata == comp_rdata[i*DATA_W +: DATA_W]));
        // R1
        write_blocks_data_chk: assert property (@(posedge clk) disable iff (rst)
            (comp_sel == (N_COMP'(1) << i) && pwrite) |-> (prdata == '0));
    end
endmodule

// File: tb/test_apb_ret_combiner.sv
module test_apb_ret_combiner;
    localparam int N = 4;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst;
    logic           pwrite, penable;
    logic [N-1:0]   comp_sel, comp_ready, comp_err;
    logic [N*W-1:0] comp_rdata;
    logic [W-1:0]   prdata;
    logic           pready, pslverr;
    logic           own_p, own_s, sel_p, sel_s;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // model state for registered flags
    bit m_own_p, m_own_s, m_sel_p, m_sel_s;

    always #2 clk = ~clk;

    apb_ret_combiner #(.N_COMP(N), .DATA_W(W)) i_apb_ret_combiner (
        .clk(clk), .rst(rst), .pwrite(pwrite), .penable(penable),
        .comp_sel(comp_sel), .comp_rdata(comp_rdata),
        .comp_ready(comp_ready), .comp_err(comp_err),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .own_err_pulse(own_p), .own_err_sticky(own_s),
        .sel_err_pulse(sel_p), .sel_err_sticky(sel_s)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive, check combined outputs, clock, check flags
    task automatic step(input string tag, input logic [N-1:0] s, input logic wr,
                        input logic en, input logic [N*W-1:0] d,
                        input logic [N-1:0] rdy, input logic [N-1:0] er);
        logic [W-1:0] e_data;
        bit e_rdy, e_err, stray, multi, nsel;
        int cnt;
        @(negedge clk);
        comp_sel = s; pwrite = wr; penable = en;
        comp_rdata = d; comp_ready = rdy; comp_err = er;
        #1;
        e_data = '0; e_rdy = 0; e_err = 0; stray = 0; cnt = 0;
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] word;
            word = d[i*W +: W];
            if (s[i]) begin
                cnt++;
                if (!wr) e_data = e_data | word;
                if (rdy[i]) e_rdy = 1;
                if (er[i]) e_err = 1;
            end else if (word != 0) begin
                stray = 1;
            end
        end
        if (cnt == 0) e_rdy = 1;
        nsel  = cnt > 1;
        multi = nsel && en && !wr;
        chk(tag, "prdata", 64'(prdata), 64'(e_data));
        chk(tag, "pready", 64'(pready), 64'(e_rdy));
        chk(tag, "pslverr", 64'(pslverr), 64'(e_err));
        m_own_p = stray || multi;
        m_own_s = m_own_s || m_own_p;
        m_sel_p = nsel;
        m_sel_s = m_sel_s || nsel;
        @(posedge clk); #1;
        chk(tag, "own_err_pulse", 64'(own_p), 64'(m_own_p));
        chk(tag, "own_err_sticky", 64'(own_s), 64'(m_own_s));
        chk(tag, "sel_err_pulse", 64'(sel_p), 64'(m_sel_p));
        chk(tag, "sel_err_sticky", 64'(sel_s), 64'(m_sel_s));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        comp_sel = '0; pwrite = 0; penable = 0;
        comp_rdata = '0; comp_ready = '0; comp_err = '0;
        @(posedge clk); #1;
        m_own_p = 0; m_own_s = 0; m_sel_p = 0; m_sel_s = 0;
        // R8 flags cleared by reset
        chk("R8", "own_err_pulse", 64'(own_p), 0);
        chk("R8", "own_err_sticky", 64'(own_s), 0);
        chk("R8", "sel_err_pulse", 64'(sel_p), 0);
        chk("R8", "sel_err_sticky", 64'(sel_s), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [N*W-1:0] put(input int idx, input logic [W-1:0] v);
        logic [N*W-1:0] r;
        r = '0;
        r[idx*W +: W] = v;
        return r;
    endfunction

    initial begin
        rst = 1'b1;
        comp_sel = '0; pwrite = 0; penable = 0;
        comp_rdata = '0; comp_ready = '0; comp_err = '0;
        m_own_p = 0; m_own_s = 0; m_sel_p = 0; m_sel_s = 0;
        do_reset();

        // R3 idle: ready high, error low
        step("R3", '0, 0, 0, '0, '0, '0);

        // R1 single reads to each completer, setup then access
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] v;
            v = 32'hA5C3_0000 + 32'(i * 32'h0101);
            step("R1", N'(1) << i, 0, 0, put(i, v), '0, '0);
            step("R1", N'(1) << i, 0, 1, put(i, v), N'(1) << i, '0);
        end

        // R1 selected write with nonzero data must give prdata 0
        step("R1", 4'b0100, 1, 1, put(2, 32'hFFFF_FFFF), 4'b0100, '0);

        // R3 error and ready from selected only; unselected ignored
        step("R3", 4'b0010, 0, 1, put(1, 32'h1234_5678), 4'b1101, 4'b1101);
        step("R3", 4'b0010, 0, 1, put(1, 32'h1234_5678), 4'b0010, 4'b0010);

        // R9 and R4 stray driver on completer 3 during read of 0
        step("R9", 4'b0001, 0, 1, put(0, 32'h0000_00C0) | put(3, 32'h8000_0001),
             4'b0001, '0);
        // R7 pulse drops, sticky holds
        step("R7", '0, 0, 0, '0, '0, '0);
        step("R7", '0, 0, 0, '0, '0, '0);

        do_reset();

        // R4 stray driver while idle
        step("R4", '0, 0, 0, put(2, 32'h0000_0010), '0, '0);
        step("R7", '0, 0, 0, '0, '0, '0);

        do_reset();

        // R2 R5 R6 two completers read in access phase
        step("R2", 4'b1010, 0, 1, put(1, 32'h00F0_000F) | put(3, 32'h0F00_00F0),
             4'b1000, 4'b0010);
        step("R7", '0, 0, 0, '0, '0, '0);

        do_reset();

        // R6 multi-hot write: select conflict only, no ownership fault
        step("R6", 4'b0011, 1, 1, put(0, 32'h1) | put(1, 32'h2), 4'b0011, '0);
        // R5 multi-hot read in setup phase: conflict but not contributor fault
        step("R5", 4'b0101, 0, 0, '0, '0, '0);
        step("R5", 4'b0101, 0, 1, put(0, 32'h3) | put(2, 32'h30), 4'b0101, '0);
        step("R7", '0, 0, 0, '0, '0, '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=%0d expected<=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule